// File: doc/BRIEF.md
# Multichannel Sample Interleaver and Packer

This block moves audio samples between a 24-bit word memory and a byte stream. When it sends samples out, it reads memory words and turns each one into a 16-bit or 32-bit item. The item is sent as bytes with the least significant byte first. When interleaving is on, the block treats memory as a set of planar per-channel blocks that sit one after another. It then emits the samples in frame order: every channel's sample `i`, then every channel's sample `i+1`, and so on.

When it takes samples in, the block collects bytes into items and writes one masked 24-bit word per item to consecutive addresses. Interleaving is not used in this direction.

A transfer begins with a single command. The command gives a format code, a count word, a base address, a direction and an interleave flag. In interleave mode, the count word carries both the channel count and the per-channel sample count. The memory port issues one access at a time, and read data returns one cycle after the read strobe.

Top module: `sample_packer`

## Requirements
- R1: A command is taken on a clock edge where `cmdValid` is high and `busy` is low. `cmdReady` equals the inverse of `busy`. A `cmdValid` while `busy` is high has no effect on the transfer in progress. `busy` rises in the cycle after a command that moves data is taken. `busy` falls in the same cycle that `done` pulses for one cycle.
- R2: Format code 1 selects 2-byte items. Codes 2 and 6 select 4-byte items. Any other code raises `err`, pulses `done` the cycle after the command, and moves no data. `err` holds until the next command is taken, and a good command clears it.
- R3: Outbound, a 2-byte item equals bits 23:8 of the memory word.
- R4: Outbound, a 4-byte item equals the memory word zero-extended to 32 bits.
- R5: Bytes of an item travel least significant byte first in both directions.
- R6: Without interleave, `count` items are transferred at addresses `base`, `base+1`, and so on, in increasing order.
- R7: With interleave, `count[3:0]` is the channel count minus one and `count[15:4]` is the samples per channel `B`. Items go out with the sample index `i` as the outer loop and the channel `ch` as the inner loop. Each item is read from `base + ch*B + i`, for a total of `B` times channels items.
- R8: Inbound, a 2-byte item is written as the item shifted left by 8 bits.
- R9: Inbound, a 4-byte item is written as its low 24 bits; the top byte is dropped.
- R10: Interleave requested with the inbound direction (`cmdToBuf` = 0) raises `err`, pulses `done` and moves no data.
- R11: A command whose item count is zero pulses `done` the cycle after it is taken, with `err` low and no data moved.
- R12: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` stays stable.
- R13: `memRe` and `memWe` are never high together. Read data is taken from `memRdata` in the cycle after `memRe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block can take a command |
| cmdFmt | input | 3 | Sample format code |
| cmdCount | input | CNT_W | Item count, or channel/sample pair in interleave mode |
| cmdBase | input | ADDR_W | First memory address |
| cmdToBuf | input | 1 | 1: memory to stream, 0: stream to memory |
| cmdInterleave | input | 1 | Planar-to-interleaved reordering |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at command end |
| err | output | 1 | Last command was rejected |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | 24 | Memory write data |
| memRdata | input | 24 | Memory read data, one cycle after `memRe` |
| outValid | output | 1 | Outbound byte valid |
| outReady | input | 1 | Outbound byte accepted |
| outData | output | 8 | Outbound byte |
| inValid | input | 1 | Inbound byte valid |
| inReady | output | 1 | Block can take an inbound byte |
| inData | input | 8 | Inbound byte |

## Verification
A wrong channel or sample counter shows up as a wrong byte value on the stream. With distinct memory contents, this appears at the very first item read from a wrong address, within about four cycles of the fault. A wrong byte counter or item width shifts every following byte and leaves the byte queue out of step when `done` arrives. A mask or shift error shows as a wrong value at the `memWe` strobe of the first affected inbound item. Random stalls on both handshakes expose any loss of data while a byte is held.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int WORD_W = 24;
  localparam int BYTE_W = 8;
  localparam int ITEM_W = 32;

  localparam logic [2:0] FMT_HALF  = 3'd1;
  localparam logic [2:0] FMT_HI24  = 3'd2;
  localparam logic [2:0] FMT_LO24  = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_LD, S_TX, S_RX, S_WR
  } spState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;
    logic shiftOut;
    logic shiftIn;
    logic wide;
  } spStrobe_t;
endpackage

// File: rtl/sp_datapath.sv
module sp_datapath
  import sp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  spStrobe_t           strobe,
  input  logic [WORD_W-1:0]   memRdata,
  input  logic [BYTE_W-1:0]   inData,
  output logic [BYTE_W-1:0]   outData,
  output logic [WORD_W-1:0]   memWdata
);
  logic [ITEM_W-1:0] itemReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      itemReg <= '0;
    end else if (strobe.loadWord) begin
      if (strobe.wide) itemReg <= {{(ITEM_W-WORD_W){1'b0}}, memRdata};
      else             itemReg <= {16'h0000, memRdata[WORD_W-1:8]};
    end else if (strobe.shiftOut) begin
      itemReg <= {{BYTE_W{1'b0}}, itemReg[ITEM_W-1:BYTE_W]};
    end else if (strobe.shiftIn) begin
      itemReg <= {inData, itemReg[ITEM_W-1:BYTE_W]};
    end
  end

  assign outData  = itemReg[BYTE_W-1:0];
  assign memWdata = strobe.wide ? itemReg[WORD_W-1:0]
                                : {itemReg[ITEM_W-1:16], 8'h00};
endmodule

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdFmt,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic              cmdToBuf,
  input  logic              cmdInterleave,
  input  logic              outReady,
  input  logic              inValid,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              outValid,
  output logic              inReady,
  output logic              memRe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output spStrobe_t         strobe
);
  localparam int CH_W = 4;

  spState_t          state;
  logic              wideQ;
  logic [ADDR_W-1:0] baseQ;
  logic [CNT_W-1:0]  blocksQ;
  logic [CH_W-1:0]   lastChQ;
  logic [CNT_W-1:0]  sampleIdx;
  logic [CH_W-1:0]   chanIdx;
  logic [ADDR_W-1:0] chanOff;
  logic [1:0]        byteCnt;
  logic              doneQ;
  logic              errQ;

  // command decode
  logic             fmtOk;
  logic             badCmd;
  logic [CNT_W-1:0] cmdBlocks;
  logic [CH_W-1:0]  cmdLastCh;

  always_comb begin
    fmtOk     = (cmdFmt == FMT_HALF) || (cmdFmt == FMT_HI24) || (cmdFmt == FMT_LO24);
    badCmd    = !fmtOk || (cmdInterleave && !cmdToBuf);
    cmdBlocks = cmdInterleave ? (cmdCount >> CH_W) : cmdCount;
    cmdLastCh = cmdInterleave ? cmdCount[CH_W-1:0] : '0;
  end

  // item walk: channel inner, sample outer
  logic              lastByte;
  logic              lastCh;
  logic              itemLast;
  logic [CH_W-1:0]   nxtChanIdx;
  logic [ADDR_W-1:0] nxtChanOff;
  logic [CNT_W-1:0]  nxtSampleIdx;

  always_comb begin
    lastByte = (byteCnt == (wideQ ? 2'd3 : 2'd1));
    lastCh   = (chanIdx == lastChQ);
    itemLast = lastCh && (sampleIdx == blocksQ - 1'b1);
    if (lastCh) begin
      nxtChanIdx   = '0;
      nxtChanOff   = '0;
      nxtSampleIdx = sampleIdx + 1'b1;
    end else begin
      nxtChanIdx   = chanIdx + 1'b1;
      nxtChanOff   = chanOff + ADDR_W'(blocksQ);
      nxtSampleIdx = sampleIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      wideQ     <= 1'b0;
      baseQ     <= '0;
      blocksQ   <= '0;
      lastChQ   <= '0;
      sampleIdx <= '0;
      chanIdx   <= '0;
      chanOff   <= '0;
      byteCnt   <= '0;
      doneQ     <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        S_IDLE: if (cmdValid) begin
          if (badCmd) begin
            errQ  <= 1'b1;
            doneQ <= 1'b1;
          end else begin
            errQ      <= 1'b0;
            wideQ     <= (cmdFmt != FMT_HALF);
            baseQ     <= cmdBase;
            blocksQ   <= cmdBlocks;
            lastChQ   <= cmdLastCh;
            sampleIdx <= '0;
            chanIdx   <= '0;
            chanOff   <= '0;
            byteCnt   <= '0;
            if (cmdBlocks == '0) doneQ <= 1'b1;
            else                 state <= cmdToBuf ? S_RD : S_RX;
          end
        end
        S_RD: state <= S_LD;
        S_LD: state <= S_TX;
        S_TX: if (outReady) begin
          byteCnt <= byteCnt + 2'd1;
          if (lastByte) begin
            byteCnt   <= '0;
            chanIdx   <= nxtChanIdx;
            chanOff   <= nxtChanOff;
            sampleIdx <= nxtSampleIdx;
            if (itemLast) begin
              state <= S_IDLE;
              doneQ <= 1'b1;
            end else begin
              state <= S_RD;
            end
          end
        end
        S_RX: if (inValid) begin
          byteCnt <= byteCnt + 2'd1;
          if (lastByte) begin
            byteCnt <= '0;
            state   <= S_WR;
          end
        end
        S_WR: begin
          chanIdx   <= nxtChanIdx;
          chanOff   <= nxtChanOff;
          sampleIdx <= nxtSampleIdx;
          if (itemLast) begin
            state <= S_IDLE;
            doneQ <= 1'b1;
          end else begin
            state <= S_RX;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign done     = doneQ;
  assign err      = errQ;
  assign outValid = (state == S_TX);
  assign inReady  = (state == S_RX);
  assign memRe    = (state == S_RD);
  assign memWe    = (state == S_WR);
  assign memAddr  = baseQ + chanOff + ADDR_W'(sampleIdx);

  assign strobe.loadWord = (state == S_LD);
  assign strobe.shiftOut = (state == S_TX) && outReady;
  assign strobe.shiftIn  = (state == S_RX) && inValid;
  assign strobe.wide     = wideQ;

  // R1
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && cmdValid |=> $stable(baseQ) && $stable(blocksQ) && $stable(wideQ));

  // R2 R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !busy && !memRe && !memWe && !outValid && !inReady);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7
  walk_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> (sampleIdx < blocksQ) && (chanIdx <= lastChQ));

  // R13
  rd_data_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> !memRe && !memWe && !outValid);
endmodule

// File: rtl/sample_packer.sv
module sample_packer
  import sp_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdFmt,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic              cmdToBuf,
  input  logic              cmdInterleave,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              memRe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [23:0]       memWdata,
  input  logic [23:0]       memRdata,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData
);
  spStrobe_t strobe;

  sp_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdFmt(cmdFmt), .cmdCount(cmdCount),
    .cmdBase(cmdBase), .cmdToBuf(cmdToBuf), .cmdInterleave(cmdInterleave),
    .outReady(outReady), .inValid(inValid),
    .busy(busy), .done(done), .err(err),
    .outValid(outValid), .inReady(inReady),
    .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .strobe(strobe)
  );

  sp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .memRdata(memRdata), .inData(inData),
    .outData(outData), .memWdata(memWdata)
  );

  assign cmdReady = !busy;

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  // R13
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));
endmodule

// File: tb/tb_sample_packer.sv
`timescale 1ns/1ps
module tb_sample_packer;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = 16;
  localparam int MEM_N  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [2:0] cmdFmt = '0;
  logic [CNT_W-1:0] cmdCount = '0;
  logic [ADDR_W-1:0] cmdBase = '0;
  logic cmdToBuf = 1'b0;
  logic cmdInterleave = 1'b0;
  logic busy, done, err, memRe, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [23:0] memWdata;
  logic [23:0] memRdata = '0;
  logic outValid;
  logic outReady = 1'b0;
  logic [7:0] outData;
  logic inValid = 1'b0;
  logic inReady;
  logic [7:0] inData = '0;

  always #10 clk = ~clk;

  sample_packer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (.*);

  // memory model: read data one cycle after memRe
  logic [23:0] mem [0:MEM_N-1];
  always @(posedge clk) begin
    if (memRe) memRdata <= mem[memAddr];
    if (memWe) mem[memAddr] <= memWdata;
  end

  int nChk = 0;
  int nFail = 0;
  int act = 0;
  int cyc = 0;
  string curReq = "R6";
  logic [7:0]  expOut[$];
  logic [7:0]  inQ[$];
  logic [ADDR_W-1:0] expWrAddr[$];
  logic [23:0] expWrData[$];

  task automatic chk(string req, logic [31:0] a, logic [31:0] e);
    nChk++;
    if (a !== e) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  // reference: stimulus on negedge, handshake evaluation just before posedge
  always @(negedge clk) begin
    cyc++;
    outReady = (cyc % 3) != 1;
    inValid  = (inQ.size() > 0) && ((cyc % 4) != 2);
    inData   = (inQ.size() > 0) ? inQ[0] : 8'h00;
    #8;
    if (rstN) begin
      if (outValid || inReady || memRe || memWe) act++;
      if (outValid && outReady) begin
        if (expOut.size() == 0) chk({curReq, " extra byte"}, 32'(outData), 32'hDEAD);
        else chk(curReq, 32'(outData), 32'(expOut.pop_front()));
      end
      if (inValid && inReady) void'(inQ.pop_front());
      if (memWe) begin
        if (expWrAddr.size() == 0) chk({curReq, " extra write"}, 32'(memAddr), 32'hDEAD);
        else begin
          chk({curReq, " addr"}, 32'(memAddr), 32'(expWrAddr.pop_front()));
          chk(curReq, 32'(memWdata), 32'(expWrData.pop_front()));
        end
      end
    end
  end

  // R3 R4 R5 R6 R7: expected outbound bytes
  task automatic planOut(int fmt, int count, int base, bit il);
    int blocks = il ? (count >> 4) : count;
    int chans  = il ? (count & 15) + 1 : 1;
    for (int i = 0; i < blocks; i++)
      for (int ch = 0; ch < chans; ch++) begin
        logic [23:0] v = mem[(base + ch*blocks + i) % MEM_N];
        logic [31:0] item = (fmt == 1) ? {16'h0, v[23:8]} : {8'h0, v};
        int nb = (fmt == 1) ? 2 : 4;
        for (int b = 0; b < nb; b++) expOut.push_back(item[8*b +: 8]);
      end
  endtask

  // R5 R8 R9: inbound bytes and expected writes
  task automatic planIn(int fmt, int count, int base, int seed);
    for (int k = 0; k < count; k++) begin
      logic [31:0] item = 32'(seed * 32'h9E3779B1 + k * 32'h7F4A7C15) | 32'h80000000;
      int nb = (fmt == 1) ? 2 : 4;
      for (int b = 0; b < nb; b++) inQ.push_back(item[8*b +: 8]);
      expWrAddr.push_back(ADDR_W'(base + k));
      expWrData.push_back((fmt == 1) ? {item[15:0], 8'h00} : item[23:0]);
    end
  endtask

  task automatic runCmd(string req, int fmt, int count, int base, bit toBuf, bit il,
                        bit expErr, bit immediate, bit poke);
    curReq = req;
    act = 0;
    @(negedge clk);
    cmdFmt = 3'(fmt); cmdCount = CNT_W'(count); cmdBase = ADDR_W'(base);
    cmdToBuf = toBuf; cmdInterleave = il; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    #5;
    // R1: busy rises after a data-moving command; R2 R10 R11: immediate finish
    chk({req, " R1 busy"}, 32'(busy), immediate ? 32'd0 : 32'd1);
    chk({req, " R1 cmdReady"}, 32'(cmdReady), immediate ? 32'd1 : 32'd0);
    chk({req, " done timing"}, 32'(done), immediate ? 32'd1 : 32'd0);
    if (poke) begin
      // R1: command while busy is ignored
      @(negedge clk);
      cmdFmt = 3'd2; cmdCount = 16'd7; cmdBase = '0; cmdToBuf = 1'b1; cmdValid = 1'b1;
      @(negedge clk);
      cmdValid = 1'b0;
      #5;
    end
    while (!done) begin
      @(posedge clk);
      #15;
    end
    chk({req, " R1 busy at done"}, 32'(busy), 32'd0);
    chk({req, " err"}, 32'(err), 32'(expErr));
    chk({req, " bytes left"}, 32'(expOut.size()), 32'd0);
    chk({req, " writes left"}, 32'(expWrAddr.size()), 32'd0);
    chk({req, " input left"}, 32'(inQ.size()), 32'd0);
    if (immediate) chk({req, " no activity"}, 32'(act), 32'd0);
  endtask

  initial begin
    for (int a = 0; a < MEM_N; a++) mem[a] = 24'(a * 40503 + 24'h3C5A11) ^ 24'(a << 13);
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
    @(posedge clk); #15;
    chk("reset busy", 32'(busy), 0);
    chk("reset outValid", 32'(outValid), 0);
    chk("reset inReady", 32'(inReady), 0);
    chk("reset mem", 32'({memRe, memWe}), 0);
    chk("reset done/err", 32'({done, err}), 0);

    planOut(1, 5, 100, 0);
    runCmd("R3 R6 half out", 1, 5, 100, 1, 0, 0, 0, 0);
    planOut(2, 3, 200, 0);
    runCmd("R4 R5 wide out", 2, 3, 200, 1, 0, 0, 0, 0);
    planOut(6, 16'h42, 300, 1);
    runCmd("R7 interleave 3ch", 6, 16'h42, 300, 1, 1, 0, 0, 0);
    planOut(1, 16'h31, 400, 1);
    runCmd("R7 interleave 2ch half", 1, 16'h31, 400, 1, 1, 0, 0, 1);
    planIn(1, 4, 500, 3);
    runCmd("R8 half in", 1, 4, 500, 0, 0, 0, 0, 0);
    planIn(2, 3, 520, 7);
    runCmd("R9 wide in", 2, 3, 520, 0, 0, 0, 0, 0);
    planOut(6, 3, 520, 0);
    runCmd("R9 readback", 6, 3, 520, 1, 0, 0, 0, 0);
    runCmd("R2 bad format", 3, 4, 10, 1, 0, 1, 1, 0);
    planOut(2, 2, 40, 0);
    runCmd("R2 err clears", 2, 2, 40, 1, 0, 0, 0, 0);
    runCmd("R10 interleave inbound", 1, 16'h21, 10, 0, 1, 1, 1, 0);
    runCmd("R11 zero count", 2, 0, 10, 1, 0, 0, 1, 0);
    runCmd("R11 zero blocks", 1, 16'h05, 10, 1, 1, 0, 1, 0);
    planOut(1, 1, MEM_N - 1, 0);
    runCmd("R6 single item", 1, 1, MEM_N - 1, 1, 0, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule